// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It watches an oversampled clock line and an open-drain data line, finds start and stop conditions, shifts in eight-bit words MSB first and acknowledges each one by pulling the data line low in the ninth clock. No device-address byte exists: every command opens with a two-byte word address. Data bytes that follow the address fill a page buffer. A stop then commits the buffer into the byte array during a self-timed write interval, and the slave stays busy for that interval.

A read is requested by sending a repeated start straight after the two address bytes. The slave then sends the byte at that address and keeps sending the next ones for as long as the master acknowledges. The write interval is counted in system clocks (`WRITE_CYCLES`, at least one page long) so that a test can use a short value. The word address is `ADDR_W` bits wide; the backing store holds `2**STORE_W` bytes, and word addresses beyond it fold onto it.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA (sdaOe = 0). Words clocked without a preceding start are not acknowledged. A stop returns the slave to standby with SDA released.
- R2: When not busy, the slave drives SDA low (sdaOe = 1) in the ninth clock of every received address or data word.
- R3: The word address is taken MSB first from two bytes. Bits of the first byte above ADDR_W are ignored, so with ADDR_W = 14 the bytes 0xC1, 0x05 select address 0x0105.
- R4: During a page write the low 6 address bits (page of 64 bytes) step by one per byte and wrap inside the page while the page bits stay fixed. Bytes of the page that are not written keep their old contents.
- R5: A write interval starts only when a stop follows at least one data byte. A stop right after the address leaves the slave ready, and memory is unchanged.
- R6: For WRITE_CYCLES clocks after a committing stop, the slave acknowledges nothing. After that interval it acknowledges again.
- R7: A repeated start right after the two address bytes starts a read. The byte at the address is sent MSB first, each bit launched after an SCL falling edge, and SDA is released in the acknowledge slot.
- R8: While the master acknowledges, the slave keeps sending bytes from successive addresses, crossing page boundaries. A master no-acknowledge ends the read with SDA released.
- R9: SDA, as driven by the slave, changes only after an SCL falling edge or on a start or stop. It is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line from the bus |
| sdaIn | input | 1 | Sensed level of the data line |
| sdaOe | output | 1 | Pull the data line low when 1 (open-drain) |

## Verification
The bench writes a page starting two bytes before the end of that page. A design that let the address carry into the page bits would put the last bytes in the next page, and the read-back of the page start would show it. A stop that follows only an address must not make the slave busy, and a poll made right after a real write must see no acknowledge. A wrong busy rule shows up as a missing or an extra acknowledge. Sequential reads are run across a page boundary, and the upper bits of the first address byte are set, so a read pointer that wraps inside the page, or an address taken without masking, returns the wrong byte.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_READ
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic relSda;
    logic setAddrHi;
    logic setAddrLo;
    logic storeByte;
    logic clearBuf;
    logic startCommit;
  } dpCtl_t;

  // events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
    logic busy;
  } busEv_t;

endpackage

// File: rtl/twi_eeprom_dp.sv
module twi_eeprom_dp
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PAGE_W       = 6,
  parameter int STORE_W      = 11,
  parameter int WRITE_CYCLES = 1250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  dpCtl_t ctl,
  output busEv_t ev,
  output logic   sdaLow
);

  localparam int PAGE_BYTES  = 1 << PAGE_W;
  localparam int STORE_BYTES = 1 << STORE_W;
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1);
  localparam int PGN_W       = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_W-1:0] OFF_ONE  = 1;
  localparam logic [PAGE_W:0]   IDX_ONE  = 1;
  localparam logic [CNT_W-1:0]  CNT_ONE  = 1;
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  // bus sampling
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  // shift register, address counter, SDA driver
  logic [7:0]        shiftReg;
  logic [7:0]        addrHi;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rdByte;
  logic              busy;

  logic [7:0] mem [STORE_BYTES];
  assign rdByte = mem[addr[STORE_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrHi   <= '0;
      addr     <= '0;
      sdaLow   <= 1'b0;
    end else begin
      if (ctl.shiftIn) shiftReg <= {shiftReg[6:0], sdaS};
      if (ctl.setAddrHi) addrHi <= shiftReg;
      if (ctl.setAddrLo) addr <= ADDR_W'({addrHi, shiftReg});
      if (ctl.storeByte)
        addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + OFF_ONE;
      if (ctl.loadTx) begin
        shiftReg <= rdByte;
        addr     <= addr + ADDR_ONE;
        sdaLow   <= ~rdByte[7];
      end else if (ctl.relSda) begin
        sdaLow <= 1'b0;
      end else if (ctl.driveAck) begin
        sdaLow <= 1'b1;
      end else if (ctl.shiftTx) begin
        shiftReg <= {shiftReg[6:0], 1'b0};
        sdaLow   <= ~shiftReg[6];
      end
    end
  end

  // page buffer and self-timed commit
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [CNT_W-1:0]      busyCnt;
  logic [PAGE_W:0]       commitIdx;
  logic [PGN_W-1:0]      commitPage;
  logic                  commitWr;

  assign commitWr = busy && !commitIdx[PAGE_W] && validMask[commitIdx[PAGE_W-1:0]];

  always_ff @(posedge clk) begin
    if (ctl.storeByte) pageBuf[addr[PAGE_W-1:0]] <= shiftReg;
    if (commitWr)
      mem[STORE_W'({commitPage, commitIdx[PAGE_W-1:0]})] <= pageBuf[commitIdx[PAGE_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      busyCnt    <= '0;
      commitIdx  <= '0;
      commitPage <= '0;
      validMask  <= '0;
    end else if (busy) begin
      if (!commitIdx[PAGE_W]) commitIdx <= commitIdx + IDX_ONE;
      if (busyCnt == '0) begin
        busy      <= 1'b0;
        validMask <= '0;
      end else begin
        busyCnt <= busyCnt - CNT_ONE;
      end
    end else if (ctl.startCommit) begin
      busy       <= 1'b1;
      busyCnt    <= CNT_LOAD;
      commitIdx  <= '0;
      commitPage <= addr[ADDR_W-1:PAGE_W];
    end else if (ctl.clearBuf) begin
      validMask <= '0;
    end else if (ctl.storeByte) begin
      validMask[addr[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_comb begin
    ev.sclRise  = sclS & ~sclPrev;
    ev.sclFall  = ~sclS & sclPrev;
    ev.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.sdaBit   = sdaS;
    ev.busy     = busy;
  end

  // SDA moves only after an SCL fall or on start/stop
  assert_sda_after_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> $past(ev.sclFall || ev.startDet || ev.stopDet));

  // page bits of the address stay put while a page is filled
  assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.storeByte |=> $stable(addr[ADDR_W-1:PAGE_W]));

  // a write interval only begins on a stop
  assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ev.stopDet));

  // nothing is driven during the write interval
  assert_quiet_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaLow);

endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  busEv_t ev,
  output dpCtl_t ctl
);

  busState_t st, stNext;
  logic [3:0] bitCnt, bitNext;
  logic ackPhase, ackPhNext;
  logic txFresh, freshNext;
  logic masterAck, mAckNext;
  logic haveData, haveNext;

  always_comb begin
    ctl       = '0;
    stNext    = st;
    bitNext   = bitCnt;
    ackPhNext = ackPhase;
    freshNext = txFresh;
    mAckNext  = masterAck;
    haveNext  = haveData;
    if (ev.stopDet) begin
      ctl.relSda = 1'b1;
      if (st == ST_WDATA && haveData) ctl.startCommit = 1'b1;
      stNext    = ST_IDLE;
      ackPhNext = 1'b0;
      freshNext = 1'b0;
      haveNext  = 1'b0;
    end else if (ev.startDet && !ev.busy) begin
      ctl.relSda = 1'b1;
      bitNext    = '0;
      ackPhNext  = 1'b0;
      haveNext   = 1'b0;
      if (st == ST_WDATA && !haveData) begin
        stNext    = ST_READ;
        freshNext = 1'b1;
      end else begin
        stNext        = ST_ADDR_HI;
        ctl.clearBuf  = 1'b1;
        freshNext     = 1'b0;
      end
    end else if (st == ST_READ) begin
      if (ev.sclFall) begin
        if (txFresh) begin
          ctl.loadTx = 1'b1;
          freshNext  = 1'b0;
        end else if (ackPhase) begin
          ackPhNext = 1'b0;
          bitNext   = '0;
          if (masterAck) begin
            ctl.loadTx = 1'b1;
          end else begin
            ctl.relSda = 1'b1;
            stNext     = ST_IDLE;
          end
        end else if (bitCnt == 4'd8) begin
          ackPhNext  = 1'b1;
          ctl.relSda = 1'b1;
        end else if (bitCnt != 4'd0) begin
          ctl.shiftTx = 1'b1;
        end
      end else if (ev.sclRise) begin
        if (ackPhase) mAckNext = ~ev.sdaBit;
        else if (bitCnt < 4'd8) bitNext = bitCnt + 4'd1;
      end
    end else if (st != ST_IDLE) begin
      if (ev.sclRise && !ackPhase && bitCnt < 4'd8) begin
        ctl.shiftIn = 1'b1;
        bitNext     = bitCnt + 4'd1;
      end else if (ev.sclFall) begin
        if (ackPhase) begin
          ctl.relSda = 1'b1;
          ackPhNext  = 1'b0;
          bitNext    = '0;
          if (st == ST_ADDR_HI) stNext = ST_ADDR_LO;
          else if (st == ST_ADDR_LO) stNext = ST_WDATA;
        end else if (bitCnt == 4'd8) begin
          ctl.driveAck = 1'b1;
          ackPhNext    = 1'b1;
          case (st)
            ST_ADDR_HI: ctl.setAddrHi = 1'b1;
            ST_ADDR_LO: ctl.setAddrLo = 1'b1;
            default: begin
              ctl.storeByte = 1'b1;
              haveNext      = 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      txFresh   <= 1'b0;
      masterAck <= 1'b0;
      haveData  <= 1'b0;
    end else begin
      st        <= stNext;
      bitCnt    <= bitNext;
      ackPhase  <= ackPhNext;
      txFresh   <= freshNext;
      masterAck <= mAckNext;
      haveData  <= haveNext;
    end
  end

  // while the write interval runs the protocol engine sits in standby
  assert_idle_when_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    ev.busy |-> st == ST_IDLE);

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PAGE_W       = 6,
  parameter int STORE_W      = 11,
  parameter int WRITE_CYCLES = 1250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  dpCtl_t ctl;
  busEv_t ev;
  logic   sdaLow;

  twi_eeprom_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .ev   (ev),
    .ctl  (ctl)
  );

  twi_eeprom_dp #(
    .ADDR_W       (ADDR_W),
    .PAGE_W       (PAGE_W),
    .STORE_W      (STORE_W),
    .WRITE_CYCLES (WRITE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .ctl    (ctl),
    .ev     (ev),
    .sdaLow (sdaLow)
  );

  assign sdaOe = sdaLow;

endmodule

// File: tb/tb_twi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_twi_eeprom_slave;

  localparam int WCYC = 300;
  localparam int H    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic bus;

  assign bus = mSda & ~sdaOe;
  always #2 clk = ~clk;

  twi_eeprom_slave #(.WRITE_CYCLES(WCYC)) dut (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (mScl),
    .sdaIn (bus),
    .sdaOe (sdaOe)
  );

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       expQ[$];
  logic [7:0] obsQ[$];
  logic [7:0] wq[$];
  logic [7:0] rq[$];
  int total = 0;
  int bad   = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string req);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  // monitor: pairs observed results with the expected items in order
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0 && expQ.size() > 0) begin
        exp_t e;
        logic [7:0] o;
        e = expQ.pop_front();
        o = obsQ.pop_front();
        chk(o, e.val, e.req);
      end
    end
  end

  task automatic hs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    mSda = 1'b1; hs(H/2);
    mScl = 1'b1; hs(H);
    mSda = 1'b0; hs(H);
    mScl = 1'b0; hs(H/2);
  endtask

  task automatic stopC();
    hs(H/2); mSda = 1'b0;
    hs(H/2); mScl = 1'b1;
    hs(H);   mSda = 1'b1;
    hs(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    logic a;
    expQ.push_back('{val: {7'd0, expAck}, req: req});
    for (int i = 7; i >= 0; i--) begin
      hs(H/2); mSda = b[i];
      hs(H/2); mScl = 1'b1;
      hs(H);   mScl = 1'b0;
    end
    hs(H/2); mSda = 1'b1;
    hs(H/2); mScl = 1'b1;
    hs(H/2); a = ~bus;
    hs(H/2); mScl = 1'b0;
    obsQ.push_back({7'd0, a});
  endtask

  task automatic recvByte(input logic [7:0] expv, input logic ackIt, input string req);
    logic [7:0] b;
    logic first;
    expQ.push_back('{val: expv, req: req});
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hs(H);   mScl = 1'b1;
      hs(H/4); first = bus;
      hs(H/4); b[i] = bus;
      hs(H/2);
      chk({7'd0, bus}, {7'd0, first}, "R9 SDA stable while SCL high");
      mScl = 1'b0;
    end
    hs(H/2); mSda = ~ackIt;
    hs(H/2); mScl = 1'b1;
    hs(H);   mScl = 1'b0;
    hs(H/2); mSda = 1'b1;
    obsQ.push_back(b);
  endtask

  task automatic writeSeq(input logic [15:0] a);
    startC();
    sendByte(a[15:8], 1'b1, "R2 address high ack");
    sendByte(a[7:0], 1'b1, "R2 address low ack");
    foreach (wq[i]) sendByte(wq[i], 1'b1, "R2 data ack");
    stopC();
    hs(WCYC + 60);
  endtask

  task automatic readSeq(input logic [15:0] a, input string req);
    startC();
    sendByte(a[15:8], 1'b1, "R3 address high ack");
    sendByte(a[7:0], 1'b1, "R3 address low ack");
    startC();
    foreach (rq[i]) recvByte(rq[i], (i != rq.size() - 1), req);
    stopC();
    chk({7'd0, sdaOe}, 8'h00, "R8 SDA released after read end");
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    hs(10);
    rstN = 1'b1;
    hs(5);
    chk({7'd0, sdaOe}, 8'h00, "R1 SDA released after reset");

    // R1: a word without a start is not acknowledged
    mScl = 1'b0; hs(H);
    sendByte(8'h01, 1'b0, "R1 no ack without start");
    hs(H);

    // single byte write, then poll while busy (R6)
    startC();
    sendByte(8'h01, 1'b1, "R3 address high ack");
    sendByte(8'h05, 1'b1, "R2 address low ack");
    sendByte(8'hA5, 1'b1, "R2 data ack");
    stopC();
    startC();
    sendByte(8'h01, 1'b0, "R6 no ack during write interval");
    stopC();
    hs(WCYC + 60);

    // R3: upper bits of first byte ignored; R7 read after restart
    startC();
    sendByte(8'hC1, 1'b1, "R6 ack after write interval");
    sendByte(8'h05, 1'b1, "R3 address low ack");
    startC();
    recvByte(8'hA5, 1'b0, "R3 R7 read of masked address");
    stopC();
    chk({7'd0, sdaOe}, 8'h00, "R1 standby after stop");

    // R4: page wrap and partial page
    wq = {8'h77};
    writeSeq(16'h0242);
    wq = {8'h11, 8'h22, 8'h33, 8'h44};
    writeSeq(16'h027E);
    rq = {8'h11, 8'h22};
    readSeq(16'h027E, "R4 R7 page write head");
    rq = {8'h33, 8'h44, 8'h77};
    readSeq(16'h0240, "R4 wrap in page keeps untouched byte");

    // R5: stop after address only does not start a write interval
    startC();
    sendByte(8'h01, 1'b1, "R5 address high ack");
    sendByte(8'h05, 1'b1, "R5 address low ack");
    stopC();
    startC();
    sendByte(8'h01, 1'b1, "R5 ready right after address-only stop");
    sendByte(8'h05, 1'b1, "R5 address low ack");
    startC();
    recvByte(8'hA5, 1'b0, "R5 memory unchanged");
    stopC();

    // R8: sequential read across a page boundary
    wq = {8'hB1, 8'hB2};
    writeSeq(16'h007E);
    wq = {8'h5A};
    writeSeq(16'h0080);
    rq = {8'hB1, 8'hB2, 8'h5A};
    readSeq(16'h007E, "R8 sequential read crosses page");

    hs(20);
    if (expQ.size() != 0 || obsQ.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: actual=%0d/%0d expected=0/0", expQ.size(), obsQ.size());
    end
    finishRun();
  end

endmodule